// File: doc/BRIEF.md
# Biased Pseudo-Random Stimulus Generator

This block produces the primary input sequence that drives a small sequential circuit under test during built-in self-test. A 12-bit linear feedback shift register walks through every non-zero state. Its bits are split into four groups of three, one group per circuit input. Each group feeds a lane that passes one bit straight through, ORs two bits to lean the input toward 1, or ANDs two bits to lean it toward 0. The lean is chosen so that the circuit is not pushed into the same states over and over. The third bit of each group drives no lane. It only sits between neighbouring lanes so that their values are less correlated.

The sequence starts from a fixed seed after reset. It moves one step per clock while `advance` is high, and `restart` sends it back to the seed. The stimulus vector is registered together with the register state, so both change on the same clock edge. A test controller can use `state_o` to log or compact the sequence position.

Top module: `biased_stim_gen`

## Requirements
- R1: The state register is 12 bits wide. Each step shifts it toward the higher index (new bit k = old bit k-1). The new bit 0 is the XOR of old bits 11, 6, 3 and 2 (polynomial x^12 + x^7 + x^4 + x^3 + 1). Starting from the seed, the state returns to the seed after exactly 4095 steps.
- R2: While `rst_n` is low, `state_o` is the seed 12'h275 (bit 0 first: 1,0,1,0,1,1,1,0,0,1,0,0) and `stim_o` is 4'b1001.
- R3: `restart` high at a clock edge loads the seed on that edge and takes priority over `advance`.
- R4: With `restart` and `advance` both low, `state_o` and `stim_o` keep their values.
- R5: `stim_o[0]` equals `state_o[0] OR state_o[1]`, so it is 1 for 3072 of the 4095 states in a period.
- R6: `stim_o[1]` equals `state_o[3]`, so it is 1 for 2048 states per period.
- R7: `stim_o[2]` equals `state_o[6] AND state_o[7]`, so it is 1 for only 1024 states per period.
- R8: `stim_o[3]` equals `state_o[9]`, so it is 1 for 2048 states per period. Bits 2, 4, 5, 8, 10 and 11 drive no stimulus bit.
- R9: `state_o` is never all zeros. A next state of zero is replaced by the seed.
- R10: `stim_o` and `state_o` change on the same clock edge. The first three vectors after reset are 4'b1001, 4'b0111 and 4'b0100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; loads the seed |
| restart | input | 1 | Synchronous reload of the seed |
| advance | input | 1 | Step the sequence by one on this edge |
| stim_o | output | 4 | Biased input vector {I3, I2, I1, I0} for the circuit under test |
| state_o | output | 12 | Current register state |

## Verification
The bench builds the block with its default parameters: four groups of three bits, two-input bias gates, seed 12'h275 and taps 12'h84C. With these values one full period of 4095 steps runs inside the cycle budget. That makes the period length, the absence of the zero state, and the exact count of ones on each stimulus bit over a whole period into direct, deterministic checks. Short tables of vectors worked out by hand pin the first steps, the hold behaviour and the priority of restart over advance.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  // Kind of gate a lane places between its group and its stimulus bit
  typedef enum logic [1:0] {
    LANE_PASS = 2'd0,  // first group bit drives the input directly
    LANE_HIGH = 2'd1,  // OR of the low bits: leans toward 1
    LANE_LOW  = 2'd2   // AND of the low bits: leans toward 0
  } lane_kind_e;

  // Stimulus vector for a given register state; used for reset constants
  function automatic logic [15:0] lane_eval(
    input logic [63:0] st,
    input logic [31:0] kinds,
    input int          groups,
    input int          gw,
    input int          gate_in
  );
    logic [15:0] v;
    v = '0;
    for (int g = 0; g < groups; g++) begin
      logic orr;
      logic andr;
      orr  = 1'b0;
      andr = 1'b1;
      for (int b = 0; b < gate_in; b++) begin
        orr  = orr  | st[g*gw + b];
        andr = andr & st[g*gw + b];
      end
      case (kinds[2*g +: 2])
        2'd1:    v[g] = orr;
        2'd2:    v[g] = andr;
        default: v[g] = st[g*gw];
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/bsg_lfsr_step.sv
module bsg_lfsr_step #(
  parameter int          W    = 12,
  parameter logic [W-1:0] TAPS = 12'h84C,
  parameter logic [W-1:0] SEED = 12'h275
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);

  logic         fb;
  logic [W-1:0] shifted;

  always_comb begin
    fb      = ^(cur & TAPS);
    shifted = {cur[W-2:0], fb};
    // lock-up guard: the all-zero state would repeat forever
    if (shifted == '0) begin
      nxt = SEED;
    end else begin
      nxt = shifted;
    end
  end

endmodule

// File: rtl/bsg_lane.sv
module bsg_lane
  import bsg_pkg::*;
#(
  parameter int         GATE_IN = 2,
  parameter lane_kind_e KIND    = LANE_PASS
) (
  input  logic [GATE_IN-1:0] bits_i,
  output logic               bit_o
);

  generate
    if (KIND == LANE_HIGH) begin : g_high
      assign bit_o = |bits_i;
    end else if (KIND == LANE_LOW) begin : g_low
      assign bit_o = &bits_i;
    end else begin : g_pass
      logic unused_rest;
      assign unused_rest = ^bits_i[GATE_IN-1:0];
      assign bit_o       = bits_i[0] | (unused_rest & 1'b0);
    end
  endgenerate

endmodule

// File: rtl/biased_stim_gen.sv
module biased_stim_gen
  import bsg_pkg::*;
#(
  parameter int  GROUPS  = 4,
  parameter int  GROUP_W = 3,
  parameter int  GATE_IN = 2,
  parameter logic [GROUPS*GROUP_W-1:0] SEED = 12'h275,
  parameter logic [GROUPS*GROUP_W-1:0] TAPS = 12'h84C,
  // two bits per lane, lane 0 in the low bits: I3 pass, I2 low, I1 pass, I0 high
  parameter logic [2*GROUPS-1:0]       KINDS = {2'd0, 2'd2, 2'd0, 2'd1}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        restart,
  input  logic                        advance,
  output logic [GROUPS-1:0]           stim_o,
  output logic [GROUPS*GROUP_W-1:0]   state_o
);

  localparam int W = GROUPS * GROUP_W;
  localparam logic [15:0] SEED_STIM_FULL =
    lane_eval(64'(SEED), 32'(KINDS), GROUPS, GROUP_W, GATE_IN);
  localparam logic [GROUPS-1:0] SEED_STIM = SEED_STIM_FULL[GROUPS-1:0];

  logic [W-1:0]      state_q;
  logic [W-1:0]      state_d;
  logic [W-1:0]      stepped;
  logic [GROUPS-1:0] stim_q;
  logic [GROUPS-1:0] stim_d;
  logic              load_en;

  bsg_lfsr_step #(
    .W    (W),
    .TAPS (TAPS),
    .SEED (SEED)
  ) u_step (
    .cur (state_q),
    .nxt (stepped)
  );

  // next-state selection: restart outranks advance
  always_comb begin
    load_en = restart | advance;
    if (restart) begin
      state_d = SEED;
    end else if (advance) begin
      state_d = stepped;
    end else begin
      state_d = state_q;
    end
  end

  // stimulus lanes evaluated on the next state so both registers agree
  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_lane
      bsg_lane #(
        .GATE_IN (GATE_IN),
        .KIND    (lane_kind_e'(KINDS[2*g +: 2]))
      ) u_lane (
        .bits_i (state_d[g*GROUP_W +: GATE_IN]),
        .bit_o  (stim_d[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
      stim_q  <= SEED_STIM;
    end else if (load_en) begin
      state_q <= state_d;
      stim_q  <= stim_d;
    end
  end

  assign state_o = state_q;
  assign stim_o  = stim_q;

endmodule

// File: rtl/biased_stim_gen_chk.sv
module biased_stim_gen_chk #(
  parameter int         W    = 12,
  parameter logic [W-1:0] SEED = 12'h275
) (
  input logic         clk,
  input logic         rst_n,
  input logic         restart,
  input logic         advance,
  input logic [3:0]   stim_o,
  input logic [W-1:0] state_o
);

  // R3: restart reloads the seed on the next edge
  p_restart_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> state_o == SEED);

  // R4: idle cycles hold everything
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !advance) |=> ($stable(state_o) && $stable(stim_o)));

  // R1: a step shifts the state toward the higher index
  p_shift_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && $past(rst_n)) |=> state_o[W-1:1] == $past(state_o[W-2:0]));

  // R9: never the all-zero state
  p_no_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != '0);

  // R5, R7: biased lanes agree with the register state
  p_lane_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stim_o[0] == (state_o[0] | state_o[1]));
  p_lane_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stim_o[2] == (state_o[6] & state_o[7]));

  // R2: leaving reset starts from the seed
  p_reset_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (state_o == SEED && stim_o == 4'b1001));

endmodule

bind biased_stim_gen biased_stim_gen_chk #(.W(W), .SEED(SEED)) u_chk (.*);

// File: tb/sim_biased_stim_gen.sv
module sim_biased_stim_gen;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] SEED = 12'h275;

  logic        clk;
  logic        rst_n;
  logic        restart;
  logic        advance;
  logic [3:0]  stim_o;
  logic [11:0] state_o;

  int n_chk;
  int n_bad;
  int cycles;

  biased_stim_gen u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .advance (advance),
    .stim_o  (stim_o),
    .state_o (state_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {advance, restart, expected stim, expected state}
  localparam int NROWS = 5;
  localparam logic [17:0] ROWS [NROWS] = '{
    {1'b1, 1'b0, 4'b0111, 12'h4EA},  // R10 second vector
    {1'b0, 1'b0, 4'b0111, 12'h4EA},  // R4 hold
    {1'b1, 1'b0, 4'b0100, 12'h9D4},  // R10 third vector
    {1'b1, 1'b1, 4'b1001, 12'h275},  // R3 restart beats advance
    {1'b1, 1'b0, 4'b0111, 12'h4EA}   // R1 step from seed again
  };

  function automatic logic [11:0] ref_step(input logic [11:0] s);
    return {s[10:0], s[11] ^ s[6] ^ s[3] ^ s[2]};
  endfunction

  function automatic logic [3:0] ref_stim(input logic [11:0] s);
    return {s[9], s[6] & s[7], s[3], s[0] | s[1]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic adv, input logic rs);
    advance = adv;
    restart = rs;
    @(negedge clk);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 30000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected under 30000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [11:0] mdl;
    int ones0, ones1, ones2, ones3, period;
    bit zero_seen;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    restart = 1'b0;
    advance = 1'b1;
    repeat (3) @(negedge clk);
    // R2: reset state, even with advance held high
    check("R2 state", 32'(state_o), 32'(SEED));
    check("R2 stim", 32'(stim_o), 32'h9);
    rst_n = 1'b1;
    advance = 1'b0;
    @(negedge clk);
    check("R10 first vector", 32'(stim_o), 32'h9);

    for (int i = 0; i < NROWS; i++) begin
      cyc(ROWS[i][17], ROWS[i][16]);
      check("R10 table stim", 32'(stim_o), 32'(ROWS[i][15:12]));
      check("R1 table state", 32'(state_o), 32'(ROWS[i][11:0]));
    end

    // R4: long idle
    repeat (7) cyc(1'b0, 1'b0);
    check("R4 idle state", 32'(state_o), 32'h4EA);
    check("R4 idle stim", 32'(stim_o), 32'h7);

    // R3: restart while advance low
    cyc(1'b0, 1'b1);
    check("R3 restart idle", 32'(state_o), 32'(SEED));

    // full period walk: R1, R5-R9
    mdl = SEED;
    ones0 = 0; ones1 = 0; ones2 = 0; ones3 = 0;
    period = 0;
    zero_seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      ones0 += int'(stim_o[0]);
      ones1 += int'(stim_o[1]);
      ones2 += int'(stim_o[2]);
      ones3 += int'(stim_o[3]);
      cyc(1'b1, 1'b0);
      mdl = ref_step(mdl);
      period++;
      if (state_o == '0) zero_seen = 1'b1;
      if (i < 40) begin
        check("R1 model state", 32'(state_o), 32'(mdl));
        check("R5-8 model stim", 32'(stim_o), 32'(ref_stim(mdl)));
      end
      if (state_o == SEED) break;
    end
    check("R1 period", 32'(period), 32'd4095);
    check("R9 zero state", 32'(zero_seen), 32'd0);
    check("R5 ones on bit0", 32'(ones0), 32'd3072);
    check("R6 ones on bit1", 32'(ones1), 32'd2048);
    check("R7 ones on bit2", 32'(ones2), 32'd1024);
    check("R8 ones on bit3", 32'(ones3), 32'd2048);

    // R2: asynchronous reset in mid-sequence
    repeat (5) cyc(1'b1, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    check("R2 async reset state", 32'(state_o), 32'(SEED));
    check("R2 async reset stim", 32'(stim_o), 32'h9);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0);
    check("R10 after reset", 32'(stim_o), 32'h7);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule